// File: doc/BRIEF.md
# Multiplexed-Address Dynamic Memory Controller with Row Refresh

This block sits between a simple host port and a 64K x 1 dynamic memory that is organised as 256 rows of 256 bits. The host presents a 16-bit address, a read/write flag and one write bit, and keeps its request raised until a one-cycle completion pulse arrives. A read bit is returned on that pulse. On the memory side the controller sends the address in two halves over eight shared pins. The row half goes out first and is latched by an active-low row strobe. The column half follows and is latched by an active-low column strobe. An active-low write enable marks a write.

The memory loses a row's contents when that row is opened. Every access therefore ends by raising the row strobe, which makes the array write its row latch back. A write opens the row, merges the new bit into the latch at the addressed column and writes the whole row back. A free-running interval timer requests a refresh cycle at a fixed period. A refresh cycle drives only a row address and the row strobe, with no column strobe. The refresh row comes from an internal counter that walks through every row in turn. A refresh that is due wins over a waiting host request. It never cuts into an access that has already started.

Top module: `dram_ctrl`

## Requirements
- R1: When the row strobe falls, the memory address pins carry host address bits [15:8]. When the column strobe falls, the same pins carry host address bits [7:0].
- R2: The column strobe is low only while the row strobe is low. Write enable is high (inactive) at the column strobe of a read and low at the column strobe of a write.
- R3: A read returns the bit last written to that address, or 0 if the address was never written. The bit is valid on the done pulse, and done is high for exactly one cycle per request.
- R4: A write changes only the addressed bit. The other bits of the same row keep their values.
- R5: Data survives any number of destructive row openings, both accesses and refreshes, because every opened row is written back.
- R6: A refresh cycle lowers and raises the row strobe without any column strobe.
- R7: Refresh cycles address rows 0, 1, 2, ... in increasing order and wrap from 255 back to 0.
- R8: Each refresh cycle starts no later than REF_INTERVAL + 16 clocks after the previous one, or after reset for the first.
- R9: A due refresh is served before a waiting host request. Each host row opening contains exactly one column strobe, so no refresh splits an access.
- R10: The column address is driven for at least one full clock before the column strobe falls.
- R11: During reset, both strobes and write enable are high and done is low.
- R12: The row strobe stays low for at least T_RAS clocks. The column strobe stays low for at least T_CAS clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until host_done |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Bit address; [15:8] row, [7:0] column |
| host_wdata | input | 1 | Bit to write |
| host_done | output | 1 | One-cycle completion pulse |
| host_rdata | output | 1 | Read bit, valid while host_done is high |
| dram_addr | output | 8 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Active-low row strobe |
| dram_cas_n | output | 1 | Active-low column strobe |
| dram_we_n | output | 1 | Active-low write enable |
| dram_din | output | 1 | Bit sent to the memory |
| dram_dout | input | 1 | Bit returned by the memory |

## Verification
A refresh tick and a host request can fall in the same cycle. A tick can also land while an access is in flight. The bench provokes both by issuing random accesses back to back, with the request raised again right after each done pulse, across many refresh intervals.

Each row-strobe window is classified as host or refresh by counting the column strobes inside it. The bench then checks three things:
- the refresh row sequence,
- the gap between refreshes, against the interval bound,
- that each host window holds exactly one column strobe.

Every read is compared with a shadow copy of the array, which shows that no row lost data when the two activities met.

// File: rtl/dram_ctrl_pkg.sv
// Shared types for the multiplexed-address dynamic memory controller.
// Assumes a square array: row and column address are equally wide.
package dram_ctrl_pkg;

    // Sequencer states; host and refresh cycles share the precharge state.
    typedef enum logic [3:0] {
        S_IDLE,
        S_ROW,
        S_RAS,
        S_COL,
        S_CAS,
        S_DONE,
        S_PRE,
        S_REF_ROW,
        S_REF_RAS
    } seq_state_t;

    // Which value the shared address pins carry.
    typedef enum logic [1:0] {
        PH_NONE,
        PH_HOST_ROW,
        PH_HOST_COL,
        PH_REF_ROW
    } addr_phase_t;

endpackage

// File: rtl/drc_refresh_timer.sv
// Refresh interval timer and refresh row counter.
// Raises ref_pending every REF_INTERVAL clocks. The pending flag clears
// when the sequencer starts a refresh (ref_start). The row counter steps
// when the refresh row cycle ends (ref_done).
// Assumes REF_INTERVAL exceeds the longest access plus one refresh.
module drc_refresh_timer #(
    parameter int ROW_W        = 8,
    parameter int REF_INTERVAL = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_start,
    input  logic             ref_done,
    output logic             ref_pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int CNT_W = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;

    logic [CNT_W-1:0] tick_cnt;
    logic             tick;

    assign tick = (tick_cnt == CNT_W'(REF_INTERVAL - 1));

    // Interval counter, pending flag and row pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt    <= '0;
            ref_pending <= 1'b0;
            ref_row     <= '0;
        end else begin
            tick_cnt <= tick ? '0 : tick_cnt + 1'b1;
            if (tick)
                ref_pending <= 1'b1;
            else if (ref_start)
                ref_pending <= 1'b0;
            if (ref_done)
                ref_row <= ref_row + 1'b1;
        end
    end

    // R8: a new tick never finds the previous refresh still unserved
    a_r8_no_missed_refresh: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> !ref_pending);

    // R7: every completed refresh advances the row pointer by one
    a_r7_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        ref_done |=> (ref_row == $past(ref_row) + 1'b1));

endmodule

// File: rtl/drc_addr_mux.sv
// Selects which address half drives the shared memory address pins.
// Purely combinational; the phase comes from the sequencer state.
module drc_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  addr_phase_t      phase,
    input  logic [ROW_W-1:0] host_row,
    input  logic [ROW_W-1:0] host_col,
    input  logic [ROW_W-1:0] ref_row,
    output logic [ROW_W-1:0] mem_addr
);
    // Phase-driven address select.
    always_comb begin
        case (phase)
            PH_HOST_ROW: mem_addr = host_row;
            PH_HOST_COL: mem_addr = host_col;
            PH_REF_ROW:  mem_addr = ref_row;
            default:     mem_addr = '0;
        endcase
    end
endmodule

// File: rtl/drc_sequencer.sv
// Strobe sequencer. Runs one host access (row phase, column phase, done,
// precharge) or one row-only refresh at a time. A refresh that is pending
// in IDLE wins over a host request. Nothing preempts a started cycle.
// Assumes T_RAS >= 1, T_CAS >= 2 (the memory latches the column one clock
// after the column strobe falls) and T_PRE >= 1 (so a held request is not
// re-accepted in the cycle after done).
module drc_sequencer
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int T_RAS = 2,
    parameter int T_CAS = 2,
    parameter int T_PRE = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               wr,
    input  logic [2*ROW_W-1:0] addr,
    input  logic               wdata,
    input  logic               ref_pending,
    input  logic               mem_dout,
    output logic               ref_start,
    output logic               ref_done,
    output addr_phase_t        phase,
    output logic [ROW_W-1:0]   row_q,
    output logic [ROW_W-1:0]   col_q,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic               mem_din,
    output logic               done,
    output logic               rdata
);
    localparam int MAX_T = (T_RAS > T_CAS) ? ((T_RAS > T_PRE) ? T_RAS : T_PRE)
                                            : ((T_CAS > T_PRE) ? T_CAS : T_PRE);
    localparam int CW    = $clog2(MAX_T + 1);

    seq_state_t    state;
    logic [CW-1:0] cnt;
    logic          wr_q;
    logic          wdata_q;
    logic          ras_last, cas_last, pre_last;

    assign ras_last  = (cnt == CW'(T_RAS - 1));
    assign cas_last  = (cnt == CW'(T_CAS - 1));
    assign pre_last  = (cnt == CW'(T_PRE - 1));
    assign ref_start = (state == S_IDLE) && ref_pending;
    assign ref_done  = (state == S_REF_RAS) && ras_last;

    // State, phase counter, request capture and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            wr_q    <= 1'b0;
            wdata_q <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            rdata   <= 1'b0;
        end else begin
            case (state)
                S_IDLE: begin
                    cnt <= '0;
                    if (ref_pending) begin
                        state <= S_REF_ROW;
                    end else if (req) begin
                        state   <= S_ROW;
                        wr_q    <= wr;
                        wdata_q <= wdata;
                        row_q   <= addr[2*ROW_W-1:ROW_W];
                        col_q   <= addr[ROW_W-1:0];
                    end
                end
                S_ROW:     begin state <= S_RAS;     cnt <= '0; end
                S_REF_ROW: begin state <= S_REF_RAS; cnt <= '0; end
                S_RAS: begin
                    if (ras_last) begin state <= S_COL; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                end
                S_REF_RAS: begin
                    if (ras_last) begin state <= S_PRE; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                end
                S_COL: begin state <= S_CAS; cnt <= '0; end
                S_CAS: begin
                    if (cas_last) begin
                        state <= S_DONE;
                        cnt   <= '0;
                        rdata <= mem_dout;
                    end else cnt <= cnt + 1'b1;
                end
                S_DONE: begin state <= S_PRE; cnt <= '0; end
                S_PRE: begin
                    if (pre_last) begin state <= S_IDLE; cnt <= '0; end
                    else cnt <= cnt + 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Strobe, write-enable and address-phase decode from the state.
    always_comb begin
        ras_n   = !(state inside {S_RAS, S_COL, S_CAS, S_REF_RAS});
        cas_n   = (state != S_CAS);
        we_n    = !(wr_q && (state inside {S_COL, S_CAS}));
        mem_din = wdata_q;
        done    = (state == S_DONE);
        case (state)
            S_ROW, S_RAS:         phase = PH_HOST_ROW;
            S_COL, S_CAS:         phase = PH_HOST_COL;
            S_REF_ROW, S_REF_RAS: phase = PH_REF_ROW;
            default:              phase = PH_NONE;
        endcase
    end

    // R2: the column strobe is only ever low inside a row strobe window
    a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R3: done never lasts longer than one cycle
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: once the column strobe is low, the access runs through to done
    a_r9_no_preempt: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> !ref_start);

endmodule

// File: rtl/dram_ctrl.sv
// Top level: host request port to a 64K x 1 multiplexed-address dynamic
// memory, with built-in periodic row refresh. Instantiates the refresh
// timer, the strobe sequencer and the address multiplexer.
// Assumes the memory opens a row when the row strobe falls, latches the
// column one clock after the column strobe falls, and writes its row latch
// back when the row strobe rises.
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W        = 8,
    parameter int REF_INTERVAL = 1500,
    parameter int T_RAS        = 2,
    parameter int T_CAS        = 2,
    parameter int T_PRE        = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_req,
    input  logic               host_wr,
    input  logic [2*ROW_W-1:0] host_addr,
    input  logic               host_wdata,
    output logic               host_done,
    output logic               host_rdata,
    output logic [ROW_W-1:0]   dram_addr,
    output logic               dram_ras_n,
    output logic               dram_cas_n,
    output logic               dram_we_n,
    output logic               dram_din,
    input  logic               dram_dout
);
    logic             ref_pending, ref_start, ref_done;
    logic [ROW_W-1:0] ref_row, row_q, col_q;
    addr_phase_t      phase;

    drc_refresh_timer #(.ROW_W(ROW_W), .REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_start   (ref_start),
        .ref_done    (ref_done),
        .ref_pending (ref_pending),
        .ref_row     (ref_row)
    );

    drc_sequencer #(.ROW_W(ROW_W), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_PRE(T_PRE)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (host_req),
        .wr          (host_wr),
        .addr        (host_addr),
        .wdata       (host_wdata),
        .ref_pending (ref_pending),
        .mem_dout    (dram_dout),
        .ref_start   (ref_start),
        .ref_done    (ref_done),
        .phase       (phase),
        .row_q       (row_q),
        .col_q       (col_q),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .mem_din     (dram_din),
        .done        (host_done),
        .rdata       (host_rdata)
    );

    drc_addr_mux #(.ROW_W(ROW_W)) u_mux (
        .phase    (phase),
        .host_row (row_q),
        .host_col (col_q),
        .ref_row  (ref_row),
        .mem_addr (dram_addr)
    );

    // R10: the column address was already on the pins the clock before
    // the column strobe falls
    a_r10_col_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_cas_n) |-> $stable(dram_addr));

    // R1: the address pins hold still while the row strobe is falling
    a_r1_row_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dram_ras_n) |-> $stable(dram_addr));

endmodule

// File: tb/dram_cell_array.sv
// Behavioural 256 x 256 dynamic array with a row latch, for the bench.
// Falling row strobe: load the row into the latch and clear the cells
// (destructive read). Falling column strobe: capture the column and, with
// write enable low, merge din. Rising row strobe: write the latch back.
module dram_cell_array #(
    parameter int ROW_W = 8
) (
    input  logic             clk,
    input  logic [ROW_W-1:0] addr,
    input  logic             ras_n,
    input  logic             cas_n,
    input  logic             we_n,
    input  logic             din,
    output logic             dout
);
    localparam int N = 1 << ROW_W;

    logic [N-1:0]     cells [N];
    logic [N-1:0]     latch;
    logic [ROW_W-1:0] row_sel, col_sel;
    logic             ras_d, cas_d, col_ok;

    initial begin
        for (int i = 0; i < N; i++) cells[i] = '0;
        latch = '0; row_sel = '0; col_sel = '0;
        ras_d = 1'b1; cas_d = 1'b1; col_ok = 1'b0;
    end

    // Strobe edge detection and array behaviour.
    always @(posedge clk) begin
        ras_d <= ras_n;
        cas_d <= cas_n;
        if (ras_d && !ras_n) begin
            row_sel        <= addr;
            latch          <= cells[addr];
            cells[addr]    <= '0;
        end
        if (cas_d && !cas_n) begin
            col_sel <= addr;
            col_ok  <= 1'b1;
            if (!we_n) latch[addr] <= din;
        end
        if (!ras_d && ras_n) begin
            cells[row_sel] <= latch;
            col_ok         <= 1'b0;
        end
    end

    assign dout = col_ok ? latch[col_sel] : 1'b0;
endmodule

// File: tb/test_dram_ctrl.sv
// Self-checking bench: random and directed host traffic against a shadow
// array, with a strobe monitor that classifies and checks every row window.
module test_dram_ctrl;
    localparam int ROW_W  = 8;
    localparam int N      = 1 << ROW_W;
    localparam int RINT   = 60;
    localparam int TRAS   = 2;
    localparam int TCAS   = 2;
    localparam int TPRE   = 2;
    localparam int SLACK  = 16;
    localparam int WD_MAX = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0, wr = 1'b0, wdata = 1'b0;
    logic [2*ROW_W-1:0] addr = '0;
    logic done, rdata, ras_n, cas_n, we_n, din, dout;
    logic [ROW_W-1:0] maddr;

    always #5 clk = ~clk;

    dram_ctrl #(.ROW_W(ROW_W), .REF_INTERVAL(RINT), .T_RAS(TRAS), .T_CAS(TCAS),
                .T_PRE(TPRE)) i_dram_ctrl (
        .clk(clk), .rst_n(rst_n), .host_req(req), .host_wr(wr), .host_addr(addr),
        .host_wdata(wdata), .host_done(done), .host_rdata(rdata), .dram_addr(maddr),
        .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_din(din),
        .dram_dout(dout));

    dram_cell_array #(.ROW_W(ROW_W)) u_array (
        .clk(clk), .addr(maddr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .din(din), .dout(dout));

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    logic [N-1:0] shadow [N];
    logic [2*ROW_W-1:0] cur_addr = '0;
    logic cur_wr = 1'b0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    function automatic bit shadow_bit(input logic [2*ROW_W-1:0] a);
        return shadow[a[2*ROW_W-1:ROW_W]][a[ROW_W-1:0]];
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_MAX) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_MAX);
            summary();
            $finish;
        end
    end

    // Strobe monitor, sampled at the falling edge.
    logic p_ras = 1'b1, p_cas = 1'b1;
    logic [ROW_W-1:0] p_addr = '0, win_row = '0;
    int ras_len = 0, cas_len = 0, cas_cnt = 0, last_ref = 0, ref_seen = 0;
    int exp_ref = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                win_row = maddr; ras_len = 0; cas_cnt = 0;
            end
            if (!ras_n) ras_len++;
            if (!cas_n) begin
                chk(!ras_n, "R2 cas inside ras", ras_n, 0);
                cas_len++;
            end
            if (p_cas && !cas_n) begin
                cas_cnt++; cas_len = 1;
                chk(win_row == cur_addr[2*ROW_W-1:ROW_W], "R1 row half", win_row,
                    cur_addr[2*ROW_W-1:ROW_W]);
                chk(maddr == cur_addr[ROW_W-1:0], "R1 column half", maddr,
                    cur_addr[ROW_W-1:0]);
                chk(maddr == p_addr, "R10 column setup", maddr, p_addr);
                chk(we_n == !cur_wr, "R2 write enable", we_n, !cur_wr);
            end
            if (!p_cas && cas_n)
                chk(cas_len >= TCAS, "R12 cas width", cas_len, TCAS);
            if (!p_ras && ras_n) begin
                chk(ras_len >= TRAS, "R12 ras width", ras_len, TRAS);
                chk(cas_cnt <= 1, "R9 one column per window", cas_cnt, 1);
                if (cas_cnt == 0) begin
                    // R6: row-only window is a refresh
                    chk(win_row == ROW_W'(exp_ref), "R7 refresh row order", win_row,
                        exp_ref % N);
                    chk(cyc - last_ref <= RINT + SLACK, "R8 R9 refresh gap",
                        cyc - last_ref, RINT + SLACK);
                    last_ref = cyc - ras_len;
                    exp_ref++;
                    ref_seen++;
                end
            end
        end
        p_ras = ras_n; p_cas = cas_n; p_addr = maddr;
    end

    task automatic access(input bit w, input logic [2*ROW_W-1:0] a, input bit d,
                          output bit r);
        @(negedge clk);
        cur_addr = a; cur_wr = w;
        addr = a; wr = w; wdata = d; req = 1'b1;
        do @(negedge clk); while (!done);
        r = rdata;
        req = 1'b0;
        @(negedge clk);
        chk(!done, "R3 done single cycle", done, 0);
    endtask

    task automatic do_write(input logic [2*ROW_W-1:0] a, input bit d);
        bit r;
        access(1'b1, a, d, r);
        shadow[a[2*ROW_W-1:ROW_W]][a[ROW_W-1:0]] = d;
    endtask

    task automatic do_read(input logic [2*ROW_W-1:0] a, input string rq);
        bit r;
        bit e;
        e = shadow_bit(a);
        access(1'b0, a, 1'b0, r);
        chk(r == e, rq, r, e);
    endtask

    initial begin
        logic [2*ROW_W-1:0] a;
        for (int i = 0; i < N; i++) shadow[i] = '0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk(ras_n && cas_n && we_n, "R11 strobes high in reset",
            {ras_n, cas_n, we_n}, 7);
        chk(!done, "R11 done low in reset", done, 0);
        rst_n = 1'b1;
        last_ref = cyc;

        // Directed corners
        do_write(16'h0000, 1'b1);
        do_write(16'hFFFF, 1'b1);
        do_write(16'h00FF, 1'b1);
        do_read(16'h0000, "R3 read corner 0000");
        do_read(16'hFFFF, "R3 read corner FFFF");
        do_read(16'h00FF, "R3 read corner 00FF");
        do_read(16'h0001, "R4 neighbour untouched");
        do_write(16'h1234, 1'b1);
        do_read(16'h1235, "R4 neighbour after write");
        do_read(16'h1233, "R4 lower neighbour after write");
        for (int k = 0; k < 4; k++) do_read(16'h1234, "R5 repeated destructive read");
        do_write(16'h1234, 1'b0);
        do_read(16'h1234, "R3 overwrite to zero");

        // Random back-to-back traffic, biased to a few rows
        for (int k = 0; k < 700; k++) begin
            a[ROW_W-1:0] = ROW_W'($urandom);
            a[2*ROW_W-1:ROW_W] = ($urandom % 2) ? ROW_W'($urandom % 4) : ROW_W'($urandom);
            if ($urandom % 2) do_write(a, 1'($urandom));
            else do_read(a, "R3 R4 random read");
        end

        // Idle long enough for the refresh row counter to wrap
        repeat (N * RINT + 4 * RINT) @(negedge clk);
        chk(ref_seen > N, "R7 refresh wrapped all rows", ref_seen, N + 1);

        // Retention after many refreshes
        for (int k = 0; k < 150; k++) begin
            a[ROW_W-1:0] = ROW_W'($urandom);
            a[2*ROW_W-1:ROW_W] = ($urandom % 2) ? ROW_W'($urandom % 4) : ROW_W'($urandom);
            do_read(a, "R5 retention after refresh");
        end
        do_read(16'hFFFF, "R5 retention corner");

        summary();
        $finish;
    end
endmodule